// File: doc/BRIEF.md
# Real-Time Clock Event and Alarm Flag Unit

This unit sits beside the time-keeping counters of a real-time clock. On every one-second tick it samples the current time and calendar values and decides which events that second produces. The possible events are a second event, a selectable time boundary, a selectable calendar boundary and an alarm. An alarm compares second, minute, hour, month and date, and each of those fields has its own enable. Each event sets a sticky status flag. A fifth flag records an update acknowledge reported by the counters.

Software works through a small register port with one write strobe and a combinational read path. Through it, software chooses the boundaries and the 12/24-hour mode, programs the alarm, reads the flags and clears them with a write-one-to-clear command. It also opens and closes interrupt sources through separate enable and disable commands that act on a readable mask. A single level interrupt reports any flag that is both set and unmasked.

Time fields arrive in BCD. The time input is packed as {pm, hour[5:0], minute[6:0], second[6:0]}, with the second in bits 6:0. The calendar input is packed as {date[5:0], weekday[2:0], month[4:0]}, with the month in bits 4:0. Weekday 1 is Monday.

Top module: `rtc_evt_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. This covers the control word, both alarm words, the status word and the mask.
- R2: Every cycle with `tick` high sets status bit 2 (second event). The flag is visible from the following cycle.
- R3: Control bits 1:0 choose the time event, which sets status bit 3. The choices are 0 = seconds 00, 1 = minutes and seconds 00, 2 = midnight and 3 = noon, both at minutes and seconds 00. Control bit 4 = 1 selects 12-hour mode. In that mode midnight is hour 0x12 with pm=0 and noon is hour 0x12 with pm=1. In 24-hour mode midnight is hour 0x00 and noon is hour 0x12.
- R4: Control bits 3:2 choose the calendar event, which sets status bit 4 and always requires midnight. The choices are 0 = weekday 1, 1 = date 0x01 and 2 = month 0x01 with date 0x01. Value 3 never sets the flag.
- R5: The alarm sets status bit 1 on a tick when every enabled field matches and at least one field is enabled. With no enables set it never fires. The pm bit is compared as part of the hour only in 12-hour mode.
- R6: A high `upd_ack` in any cycle sets status bit 0.
- R7: Flags are sticky. A write to address 4 clears each flag whose data bit is 1. When a flag is set and cleared in the same cycle, the set wins.
- R8: A write to address 5 sets mask bits and a write to address 6 clears mask bits. Both use the status bit positions. Address 7 reads the mask.
- R9: `irq` is high exactly when some status flag and its mask bit are both 1. It follows the flags with no extra delay.
- R10: The register map is 0 = control, 1 = time alarm, 2 = calendar alarm and 3 = status (read-only). The time alarm holds second 6:0 with its enable at 7, minute 14:8 with its enable at 15, and hour 21:16 with pm at 22 and its enable at 23. The calendar alarm holds month 20:16 with its enable at 23, and date 29:24 with its enable at 31. Writes to addresses 3 and 7 have no effect.
- R11: Without `tick`, none of status bits 1 to 4 is set, whatever the time inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second sample strobe |
| upd_ack | input | 1 | Update-acknowledge pulse from the counters |
| tm_now | input | 21 | Current time {pm, hour, minute, second}, BCD |
| cal_now | input | 14 | Current calendar {date, weekday, month}, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Level interrupt |

## Verification
Each flag is set on the clock edge where `tick`, `upd_ack` or a clear write is high. The bench drives these strobes for exactly one cycle from a falling edge and reads status one falling edge later, which is the first cycle the flag can show. Mask writes also take effect at that edge, so mask readback is taken one cycle after the write. `irq` and `reg_rdata` are combinational from registered state, so the bench samples them a short delay after changing the address, with no further edge in between.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int FLAG_N = 5;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int MON_W  = 5;
    localparam int DATE_W = 6;
    localparam int WDAY_W = 3;
    localparam int TIME_W = 1 + HOUR_W + MIN_W + SEC_W;
    localparam int CAL_W  = DATE_W + WDAY_W + MON_W;

    // status bit positions (shared by clear, enable, disable and mask)
    localparam int F_ACK = 0;
    localparam int F_ALM = 1;
    localparam int F_SEC = 2;
    localparam int F_TEV = 3;
    localparam int F_CEV = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_TALM = 3'd1,
        A_CALM = 3'd2,
        A_STAT = 3'd3,
        A_CLR  = 3'd4,
        A_IEN  = 3'd5,
        A_IDIS = 3'd6,
        A_MASK = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        TEV_MIN      = 2'd0,
        TEV_HOUR     = 2'd1,
        TEV_MIDNIGHT = 2'd2,
        TEV_NOON     = 2'd3
    } tev_sel_e;

    typedef enum logic [1:0] {
        CEV_WEEK  = 2'd0,
        CEV_MONTH = 2'd1,
        CEV_YEAR  = 2'd2,
        CEV_RSVD  = 2'd3
    } cev_sel_e;

    typedef struct packed {
        logic              pm;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } clk_time_t;

    typedef struct packed {
        logic [DATE_W-1:0] date;
        logic [WDAY_W-1:0] wday;
        logic [MON_W-1:0]  month;
    } clk_cal_t;

    typedef struct packed {
        logic              hour_en;
        logic              pm;
        logic [HOUR_W-1:0] hour;
        logic              min_en;
        logic [MIN_W-1:0]  min;
        logic              sec_en;
        logic [SEC_W-1:0]  sec;
    } talarm_t;

    typedef struct packed {
        logic              date_en;
        logic [DATE_W-1:0] date;
        logic              month_en;
        logic [MON_W-1:0]  month;
    } calarm_t;

    typedef struct packed {
        logic     mode12;
        cev_sel_e cev;
        tev_sel_e tev;
    } ctrl_t;

    function automatic logic is_midnight(clk_time_t t, logic mode12);
        if (mode12) return (t.hour == HOUR_W'(8'h12)) && !t.pm;
        return t.hour == '0;
    endfunction

    function automatic logic is_noon(clk_time_t t, logic mode12);
        if (mode12) return (t.hour == HOUR_W'(8'h12)) && t.pm;
        return t.hour == HOUR_W'(8'h12);
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(ctrl_t c);
        return {{(REG_W-5){1'b0}}, c.mode12, c.cev, c.tev};
    endfunction

    function automatic logic [REG_W-1:0] talarm_word(talarm_t a);
        return {8'b0, a.hour_en, a.pm, a.hour, a.min_en, a.min, a.sec_en, a.sec};
    endfunction

    function automatic logic [REG_W-1:0] calarm_word(calarm_t a);
        return {a.date_en, 1'b0, a.date, a.month_en, 2'b0, a.month, 16'b0};
    endfunction

endpackage

// File: rtl/rtc_evt_regs.sv
module rtc_evt_regs
    import rtc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [FLAG_N-1:0] flags,
    output ctrl_t             ctrl,
    output talarm_t           talm,
    output calarm_t           calm,
    output logic [FLAG_N-1:0] mask,
    output logic [FLAG_N-1:0] clr_cmd,
    output logic [REG_W-1:0]  rdata
);

    localparam int PAD_W = REG_W - FLAG_N;

    reg_addr_e          sel;
    logic [FLAG_N-1:0]  wbits;

    assign sel     = reg_addr_e'(addr);
    assign wbits   = wdata[FLAG_N-1:0];
    assign clr_cmd = (wr_en && sel == A_CLR) ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.tev    <= TEV_MIN;
            ctrl.cev    <= CEV_WEEK;
            ctrl.mode12 <= 1'b0;
            talm        <= '0;
            calm        <= '0;
            mask        <= '0;
        end else if (wr_en) begin
            case (sel)
                A_CTRL: begin
                    ctrl.tev    <= tev_sel_e'(wdata[1:0]);
                    ctrl.cev    <= cev_sel_e'(wdata[3:2]);
                    ctrl.mode12 <= wdata[4];
                end
                A_TALM: begin
                    talm.sec     <= wdata[6:0];
                    talm.sec_en  <= wdata[7];
                    talm.min     <= wdata[14:8];
                    talm.min_en  <= wdata[15];
                    talm.hour    <= wdata[21:16];
                    talm.pm      <= wdata[22];
                    talm.hour_en <= wdata[23];
                end
                A_CALM: begin
                    calm.month    <= wdata[20:16];
                    calm.month_en <= wdata[23];
                    calm.date     <= wdata[29:24];
                    calm.date_en  <= wdata[31];
                end
                A_IEN:   mask <= mask | wbits;
                A_IDIS:  mask <= mask & ~wbits;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            A_CTRL:  rdata = ctrl_word(ctrl);
            A_TALM:  rdata = talarm_word(talm);
            A_CALM:  rdata = calarm_word(calm);
            A_STAT:  rdata = {{PAD_W{1'b0}}, flags};
            A_MASK:  rdata = {{PAD_W{1'b0}}, mask};
            default: rdata = '0;
        endcase
    end

    // R8: an enable command leaves each requested mask bit set
    p_mask_en_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == A_IEN) |=> ((mask & $past(wbits)) == $past(wbits)));

    // R8: a disable command leaves each requested mask bit clear
    p_mask_dis_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == A_IDIS) |=> ((mask & $past(wbits)) == '0));

endmodule

// File: rtl/rtc_evt_detect.sv
module rtc_evt_detect
    import rtc_evt_pkg::*;
(
    input  logic              tick,
    input  logic              upd_ack,
    input  clk_time_t         tm,
    input  clk_cal_t          cal,
    input  ctrl_t             ctrl,
    input  talarm_t           talm,
    input  calarm_t           calm,
    output logic [FLAG_N-1:0] ev_set
);

    logic sec_zero, top_of_hour, at_midnight, at_noon;
    logic tev_hit, cev_hit;
    logic sec_ok, min_ok, hour_ok, month_ok, date_ok, any_en, alarm_hit;

    assign sec_zero    = (tm.sec == '0);
    assign top_of_hour = sec_zero && (tm.min == '0);
    assign at_midnight = top_of_hour && is_midnight(tm, ctrl.mode12);
    assign at_noon     = top_of_hour && is_noon(tm, ctrl.mode12);

    always_comb begin
        case (ctrl.tev)
            TEV_MIN:      tev_hit = sec_zero;
            TEV_HOUR:     tev_hit = top_of_hour;
            TEV_MIDNIGHT: tev_hit = at_midnight;
            default:      tev_hit = at_noon;
        endcase
    end

    always_comb begin
        case (ctrl.cev)
            CEV_WEEK:  cev_hit = at_midnight && (cal.wday == WDAY_W'(1));
            CEV_MONTH: cev_hit = at_midnight && (cal.date == DATE_W'(1));
            CEV_YEAR:  cev_hit = at_midnight && (cal.date == DATE_W'(1))
                                 && (cal.month == MON_W'(1));
            default:   cev_hit = 1'b0;
        endcase
    end

    assign sec_ok   = !talm.sec_en   || (tm.sec == talm.sec);
    assign min_ok   = !talm.min_en   || (tm.min == talm.min);
    assign hour_ok  = !talm.hour_en  || ((tm.hour == talm.hour)
                                         && (!ctrl.mode12 || (tm.pm == talm.pm)));
    assign month_ok = !calm.month_en || (cal.month == calm.month);
    assign date_ok  = !calm.date_en  || (cal.date == calm.date);
    assign any_en   = talm.sec_en || talm.min_en || talm.hour_en
                      || calm.month_en || calm.date_en;
    assign alarm_hit = any_en && sec_ok && min_ok && hour_ok && month_ok && date_ok;

    always_comb begin
        ev_set        = '0;
        ev_set[F_ACK] = upd_ack;
        ev_set[F_ALM] = tick && alarm_hit;
        ev_set[F_SEC] = tick;
        ev_set[F_TEV] = tick && tev_hit;
        ev_set[F_CEV] = tick && cev_hit;
    end

endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_vec[i]) flags[i] <= 1'b0;
        end
    end

    // R7: a set request always lands, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R7: a clear without a competing set empties the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (|(clr_vec & ~set_vec)) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));

    // R7: flags are sticky when nothing requests a change
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ((set_vec == '0) && (clr_vec == '0)) |=> $stable(flags));

endmodule

// File: rtl/rtc_evt_unit.sv
module rtc_evt_unit
    import rtc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              upd_ack,
    input  logic [TIME_W-1:0] tm_now,
    input  logic [CAL_W-1:0]  cal_now,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);

    ctrl_t             ctrl;
    talarm_t           talm;
    calarm_t           calm;
    logic [FLAG_N-1:0] mask, clr_cmd, ev_set, flags;
    clk_time_t         tm_s;
    clk_cal_t          cal_s;
    logic              alarm_armed;

    assign tm_s  = clk_time_t'(tm_now);
    assign cal_s = clk_cal_t'(cal_now);

    rtc_evt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .flags   (flags),
        .ctrl    (ctrl),
        .talm    (talm),
        .calm    (calm),
        .mask    (mask),
        .clr_cmd (clr_cmd),
        .rdata   (reg_rdata)
    );

    rtc_evt_detect u_detect (
        .tick    (tick),
        .upd_ack (upd_ack),
        .tm      (tm_s),
        .cal     (cal_s),
        .ctrl    (ctrl),
        .talm    (talm),
        .calm    (calm),
        .ev_set  (ev_set)
    );

    rtc_evt_flags #(.N(FLAG_N)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (ev_set),
        .clr_vec (clr_cmd),
        .flags   (flags)
    );

    assign irq = |(flags & mask);

    assign alarm_armed = talm.sec_en || talm.min_en || talm.hour_en
                         || calm.month_en || calm.date_en;

    // R2: each tick leaves the second-event flag set
    p_sec_tick_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> flags[F_SEC]);

    // R11: no event or alarm flag rises without a tick
    p_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ((flags[F_CEV:F_ALM] & ~$past(flags[F_CEV:F_ALM])) == '0));

    // R4: the reserved calendar select never raises its flag
    p_rsvd_cev_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.cev == CEV_RSVD) |=> !(flags[F_CEV] && !$past(flags[F_CEV])));

    // R5: an alarm with no field enabled never fires
    p_unarmed_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !alarm_armed) |=> !(flags[F_ALM] && !$past(flags[F_ALM])));

endmodule

// File: tb/rtc_evt_unit_tb.sv
module rtc_evt_unit_tb;
    import rtc_evt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              upd_ack = 1'b0;
    logic [TIME_W-1:0] tm_now = '0;
    logic [CAL_W-1:0]  cal_now = '0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench-side shadow of programmed state
    logic [1:0]  sh_tev = 0, sh_cev = 0;
    logic        sh_m12 = 0;
    logic [31:0] sh_talm = 0, sh_calm = 0;
    logic [4:0]  exp_flags = 0, exp_mask = 0;

    always #5 clk = ~clk;

    rtc_evt_unit u_dut (
        .clk(clk), .rst(rst), .tick(tick), .upd_ack(upd_ack),
        .tm_now(tm_now), .cal_now(cal_now), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [20:0] mk_time(input bit pm, input int h, input int m, input int s);
        logic [7:0] bh, bm, bs;
        bh = bcd(h); bm = bcd(m); bs = bcd(s);
        return {pm, bh[5:0], bm[6:0], bs[6:0]};
    endfunction

    function automatic logic [13:0] mk_cal(input int date, input int wday, input int month);
        logic [7:0] bd, bmo;
        bd = bcd(date); bmo = bcd(month);
        return {bd[5:0], 3'(wday), bmo[4:0]};
    endfunction

    // expected set vector (excluding acknowledge) for one tick
    function automatic logic [4:0] ev_bits(input logic [20:0] t, input logic [13:0] c);
        logic [6:0] s, m; logic [5:0] h; logic pm;
        logic [4:0] mo; logic [2:0] wd; logic [5:0] dt;
        logic top, mid, noon, a_ok, any, tev, cev;
        logic [4:0] r;
        s = t[6:0]; m = t[13:7]; h = t[19:14]; pm = t[20];
        mo = c[4:0]; wd = c[7:5]; dt = c[13:8];
        top  = (s == 0) && (m == 0);
        mid  = top && (sh_m12 ? (h == 6'h12 && !pm) : (h == 6'h00));
        noon = top && (h == 6'h12) && (sh_m12 ? pm : 1'b1);
        case (sh_tev)
            2'd0: tev = (s == 0);
            2'd1: tev = top;
            2'd2: tev = mid;
            default: tev = noon;
        endcase
        case (sh_cev)
            2'd0: cev = mid && (wd == 1);
            2'd1: cev = mid && (dt == 6'h01);
            2'd2: cev = mid && (dt == 6'h01) && (mo == 5'h01);
            default: cev = 1'b0;
        endcase
        any  = sh_talm[7] | sh_talm[15] | sh_talm[23] | sh_calm[23] | sh_calm[31];
        a_ok = (!sh_talm[7]  || s == sh_talm[6:0]) &&
               (!sh_talm[15] || m == sh_talm[14:8]) &&
               (!sh_talm[23] || (h == sh_talm[21:16] && (!sh_m12 || pm == sh_talm[22]))) &&
               (!sh_calm[23] || mo == sh_calm[20:16]) &&
               (!sh_calm[31] || dt == sh_calm[29:24]);
        r = 0;
        r[1] = any && a_ok;
        r[2] = 1'b1;
        r[3] = tev;
        r[4] = cev;
        return r;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_ctrl(input int tev, input int cev, input bit m12);
        sh_tev = 2'(tev); sh_cev = 2'(cev); sh_m12 = m12;
        wr(3'd0, {27'b0, m12, 2'(cev), 2'(tev)});
    endtask

    task automatic set_alarms(input logic [31:0] ta, input logic [31:0] ca);
        sh_talm = ta & 32'h00FF_FFFF;
        sh_calm = ca & 32'hBF9F_0000;
        wr(3'd1, ta);
        wr(3'd2, ca);
    endtask

    task automatic clr(input logic [4:0] b);
        wr(3'd4, {27'b0, b});
        exp_flags &= ~b;
    endtask

    task automatic check_status(input string req);
        logic [31:0] d;
        rd(3'd3, d);
        chk(req, d, {27'b0, exp_flags});
        chk("R9 irq level", {31'b0, irq}, {31'b0, |(exp_flags & exp_mask)});
    endtask

    task automatic tick_step(input logic [20:0] t, input logic [13:0] c, input string req);
        logic [31:0] d;
        @(negedge clk);
        tm_now = t; cal_now = c; tick = 1;
        @(negedge clk);
        tick = 0;
        exp_flags |= ev_bits(t, c);
        rd(3'd3, d);
        chk("R2 second event per tick", {31'b0, d[2]}, 32'd1);
        check_status(req);
    endtask

    function automatic logic [20:0] rand_time();
        int h, m, s; bit pm;
        s = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(0, 59));
        m = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(0, 59));
        if (sh_m12) begin
            h  = ($urandom_range(0, 2) == 0) ? 12 : int'($urandom_range(1, 12));
            pm = 1'($urandom_range(0, 1));
        end else begin
            case ($urandom_range(0, 3))
                0: h = 0;
                1: h = 12;
                default: h = int'($urandom_range(0, 23));
            endcase
            pm = 0;
        end
        return mk_time(pm, h, m, s);
    endfunction

    function automatic logic [13:0] rand_cal();
        int d, w, mo;
        d  = ($urandom_range(0, 1) == 0) ? 1 : int'($urandom_range(1, 31));
        w  = ($urandom_range(0, 1) == 0) ? 1 : int'($urandom_range(1, 7));
        mo = ($urandom_range(0, 1) == 0) ? 1 : int'($urandom_range(1, 12));
        return mk_cal(d, w, mo);
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [20:0] t;
        logic [13:0] c;
        void'($urandom(32'd7919));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset register value", d, 32'd0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'd0);

        // R11: matching boundary shown on inputs without a tick
        set_ctrl(0, 0, 0);
        tm_now = mk_time(0, 0, 0, 0); cal_now = mk_cal(1, 1, 1);
        repeat (4) @(negedge clk);
        check_status("R11 no flags without tick");

        // R10: register map readback and read-only addresses
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d);
        chk("R10 time alarm layout", d, 32'h00FF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d);
        chk("R10 calendar alarm layout", d, 32'hBF9F_0000);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d);
        chk("R10 control layout", d, 32'h0000_001F);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd3, d);
        chk("R10 status write ignored", d, 32'd0);
        rd(3'd7, d);
        chk("R10 mask write ignored", d, 32'd0);

        // R5: alarm values match but nothing enabled
        set_ctrl(0, 0, 0);
        set_alarms(32'h0012_3005 & 32'h007F_7F7F, 32'h0100_0000 & 32'h3F1F_0000);
        tick_step(mk_time(0, 12, 30, 5), mk_cal(1, 3, 1), "R5 unarmed alarm silent");
        clr(5'h1F);

        // R5: pm ignored in 24-hour mode, compared in 12-hour mode
        set_alarms(32'h00D2_0000, 32'h0);
        tick_step(mk_time(0, 12, 7, 9), mk_cal(5, 2, 3), "R5 pm ignored in 24h");
        clr(5'h1F);
        set_ctrl(0, 0, 1);
        tick_step(mk_time(0, 12, 7, 9), mk_cal(5, 2, 3), "R5 pm compared in 12h");
        clr(5'h1F);
        set_alarms(32'h0, 32'h0);

        // R3: 12-hour midnight and noon, 24-hour noon is not midnight
        set_ctrl(2, 0, 1);
        tick_step(mk_time(0, 12, 0, 0), mk_cal(9, 1, 4), "R3 12h midnight event");
        clr(5'h1F);
        set_ctrl(3, 0, 1);
        tick_step(mk_time(1, 12, 0, 0), mk_cal(9, 2, 4), "R3 12h noon event");
        clr(5'h1F);
        set_ctrl(2, 0, 0);
        tick_step(mk_time(0, 12, 0, 0), mk_cal(9, 2, 4), "R3 24h noon not midnight");
        clr(5'h1F);

        // R4: reserved calendar select vs year select
        set_ctrl(1, 3, 0);
        tick_step(mk_time(0, 0, 0, 0), mk_cal(1, 1, 1), "R4 reserved select silent");
        clr(5'h1F);
        set_ctrl(1, 2, 0);
        tick_step(mk_time(0, 0, 0, 0), mk_cal(1, 4, 1), "R4 year event");
        clr(5'h1F);

        // R6: update acknowledge
        @(negedge clk); upd_ack = 1;
        @(negedge clk); upd_ack = 0;
        exp_flags |= 5'h01;
        check_status("R6 acknowledge flag");

        // R7: set wins over a same-cycle clear
        set_ctrl(0, 0, 0);
        @(negedge clk);
        tm_now = mk_time(0, 3, 4, 5); cal_now = mk_cal(6, 3, 7);
        tick = 1; upd_ack = 1;
        reg_wr = 1; reg_addr = 3'd4; reg_wdata = 32'h1F;
        @(negedge clk);
        tick = 0; upd_ack = 0; reg_wr = 0;
        exp_flags = 5'h05;
        check_status("R7 set wins over clear");

        // R8/R9: mask enable, disable, interrupt level
        wr(3'd5, 32'h0000_0004);
        exp_mask = 5'h04;
        rd(3'd7, d);
        chk("R8 mask after enable", d, 32'h4);
        chk("R9 irq with unmasked flag", {31'b0, irq}, 32'd1);
        wr(3'd6, 32'h0000_0004);
        exp_mask = 5'h00;
        rd(3'd7, d);
        chk("R8 mask after disable", d, 32'h0);
        chk("R9 irq masked", {31'b0, irq}, 32'd0);
        clr(5'h1F);
        check_status("R7 clear all");

        // constrained random phase
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 3) == 0)
                set_ctrl(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                         1'($urandom_range(0, 1)));
            t = rand_time();
            c = rand_cal();
            if ($urandom_range(0, 3) == 0) begin
                logic [31:0] ta, ca;
                ta = {8'b0, 1'($urandom_range(0, 1)), t[20], t[19:14],
                      1'($urandom_range(0, 1)), t[13:7], 1'($urandom_range(0, 1)), t[6:0]};
                ca = {1'($urandom_range(0, 1)), 1'b0, c[13:8],
                      1'($urandom_range(0, 1)), 2'b0, c[4:0], 16'b0};
                if ($urandom_range(0, 1) == 0) ta[6:0] = bcd(int'($urandom_range(0, 59)));
                set_alarms(ta, ca);
            end
            if ($urandom_range(0, 2) == 0) begin
                d = {27'b0, 5'($urandom_range(0, 31))};
                wr(3'd5, d);
                exp_mask |= d[4:0];
            end
            if ($urandom_range(0, 2) == 0) begin
                d = {27'b0, 5'($urandom_range(0, 31))};
                wr(3'd6, d);
                exp_mask &= ~d[4:0];
                rd(3'd7, d);
                chk("R8 mask readback", d, {27'b0, exp_mask});
            end
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk); upd_ack = 1;
                @(negedge clk); upd_ack = 0;
                exp_flags |= 5'h01;
            end
            tick_step(t, c, "R3 R4 R5 R7 random tick status");
            if ($urandom_range(0, 1) == 0) begin
                clr(5'($urandom_range(0, 31)));
                check_status("R7 random clear");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule